// File: doc/BRIEF.md
# Byte/Word Switchable Parallel ROM Read Controller

This block lets a synchronous host read from an asynchronous parallel read-only memory. The memory can present either 16-bit words or 8-bit bytes, and its organisation is chosen per access through a mode pin. The host presents a byte address, a word/byte select and a read strobe. The controller then drives the memory's address pins, mode pin, chip-enable and output-enable. It waits a number of clock cycles that covers the memory's access times, registers the data and hands it back with a one-cycle valid pulse.

One memory pin does two jobs. In word mode it is data bit 15 and the memory drives it. In byte mode it is the least significant byte-address input and the controller drives it. The controller switches the pin's direction with the access mode. After every read it releases output-enable and waits out a disable turnaround, so that the pin is never driven from both ends.

The wait counts are fixed at elaboration from the clock period and the memory's timing figures, each rounded up to whole cycles. The enable polarities are also parameters.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the controller keeps chip-enable and output-enable inactive, leaves the shared pin undriven, holds busy and valid low, and holds the data output at zero.
- R2: A strobe seen while idle is accepted at that clock edge. From the next cycle, busy is high and chip-enable is active. The memory address pins carry host address bits [ADDR_W:1] and the mode pin carries the host select (1 = word, 0 = byte).
- R3: Output-enable becomes active one cycle after chip-enable and the address are applied, and it is never active while chip-enable is inactive.
- R4: The access count is ACC = ceil(T_ACC_NS / CLK_PERIOD_NS) and the output-enable count is OEC = ceil(T_OE_NS / CLK_PERIOD_NS). Data is captured at the edge CAP = max(ACC, OEC + 1) cycles after the accepting edge. That edge raises valid for exactly one cycle and releases both enables. With the defaults, CAP is 10.
- R5: In word mode the result is the shared pin as bit 15 above data lines 14..0.
- R6: In byte mode the shared pin is driven with host address bit 0. The result is data lines 7..0 zero-extended to 16 bits, and lines 14..8 are ignored.
- R7: The shared pin is driven only while chip-enable is active for a byte-mode access. It is never driven while idle, during turnaround or in word mode.
- R8: After the valid pulse, busy stays high for TURN = ceil(T_DIS_NS / CLK_PERIOD_NS) cycles (2 with the defaults). Only after that can a new strobe be accepted, so the shared pin is never driven sooner than TURN cycles after output-enable is released.
- R9: A strobe seen while busy is ignored. It produces no extra valid pulse and does not change the pins of the access in progress.
- R10: Address, mode and shared-pin levels stay unchanged for the whole time chip-enable is active.
- R11: With default parameters both enable pins are active low. Setting CE_ACTIVE_HIGH or OE_ACTIVE_HIGH makes that pin active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read strobe from the host |
| rd_addr_i | input | ADDR_W+1 | Host byte address |
| rd_word_i | input | 1 | Access mode: 1 word, 0 byte |
| rd_busy_o | output | 1 | Access or turnaround in progress |
| rd_valid_o | output | 1 | One-cycle pulse with returned data |
| rd_data_o | output | 16 | Returned data, byte results zero-extended |
| rom_addr_o | output | ADDR_W | Memory address pins |
| rom_word_o | output | 1 | Memory organisation select, 1 = word |
| rom_ce_o | output | 1 | Memory chip-enable pin |
| rom_oe_o | output | 1 | Memory output-enable pin |
| rom_dq_i | input | 15 | Memory data lines 14..0 |
| rom_q15_i | input | 1 | Shared pin, input side (data bit 15) |
| rom_q15_o | output | 1 | Shared pin, output side (byte address bit) |
| rom_q15_oe_o | output | 1 | Shared pin drive enable |

## Verification
Busy and chip-enable are due one cycle after the accepting edge. Output-enable follows one cycle later. Valid and the captured data are due exactly CAP cycles after the accepting edge, and busy falls TURN cycles after that. The bench numbers every rising edge and records the edge at which it expects each strobe to be accepted. On each falling edge it derives every expected pin and output level from the distance to that edge, so a result one cycle early or late shows up as a mismatch. The bench memory model returns garbage until the model's own address, chip-enable and output-enable delays have passed, so a capture made too early returns wrong data.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_TURN = 2'd2
    } rd_state_e;

    // whole cycles needed to cover a time, rounded up
    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/rom_wait_timer.sv
module rom_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rom_pin_level.sv
module rom_pin_level #(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic on_i,
    output logic pin_o
);
    generate
        if (ACTIVE_HIGH) begin : g_high
            assign pin_o = on_i;
        end else begin : g_low
            assign pin_o = ~on_i;
        end
    endgenerate
endmodule

// File: rtl/rom_data_pack.sv
module rom_data_pack (
    input  logic        word_i,
    input  logic [14:0] dq_i,
    input  logic        q15_i,
    output logic [15:0] data_o
);
    always_comb begin
        if (word_i) begin
            data_o = {q15_i, dq_i};
        end else begin
            // upper lines float in byte mode: drop them
            data_o = {8'h00, dq_i[7:0]};
        end
    end
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W         = 20,
    parameter int unsigned CLK_PERIOD_NS  = 10,
    parameter int unsigned T_ACC_NS       = 100,
    parameter int unsigned T_OE_NS        = 50,
    parameter int unsigned T_DIS_NS       = 20,
    parameter bit          CE_ACTIVE_HIGH = 1'b0,
    parameter bit          OE_ACTIVE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [ADDR_W:0]   rd_addr_i,
    input  logic              rd_word_i,
    output logic              rd_busy_o,
    output logic              rd_valid_o,
    output logic [15:0]       rd_data_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              rom_word_o,
    output logic              rom_ce_o,
    output logic              rom_oe_o,
    input  logic [14:0]       rom_dq_i,
    input  logic              rom_q15_i,
    output logic              rom_q15_o,
    output logic              rom_q15_oe_o
);
    localparam int unsigned ACC_CYC  = at_least_one(cdiv(T_ACC_NS, CLK_PERIOD_NS));
    localparam int unsigned OE_CYC   = at_least_one(cdiv(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned TURN_CYC = at_least_one(cdiv(T_DIS_NS, CLK_PERIOD_NS));
    localparam int unsigned MAX_AO   = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
    localparam int unsigned CNT_MAX  = (MAX_AO > TURN_CYC) ? MAX_AO : TURN_CYC;
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              lsb;
        logic              word;
        logic              ce;
        logic              oe;
        logic              valid;
        logic [15:0]       data;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic acc_load_d, oe_load_d, turn_load_d;
    logic acc_done, oe_done, turn_done;
    logic [15:0] packed_data;

    rom_wait_timer #(.CNT_W(CNT_W)) u_acc_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (acc_load_d),
        .load_val_i (CNT_W'(ACC_CYC - 1)),
        .done_o     (acc_done)
    );

    rom_wait_timer #(.CNT_W(CNT_W)) u_oe_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (oe_load_d),
        .load_val_i (CNT_W'(OE_CYC - 1)),
        .done_o     (oe_done)
    );

    rom_wait_timer #(.CNT_W(CNT_W)) u_turn_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (turn_load_d),
        .load_val_i (CNT_W'(TURN_CYC - 1)),
        .done_o     (turn_done)
    );

    rom_data_pack u_pack (
        .word_i (ctl_q.word),
        .dq_i   (rom_dq_i),
        .q15_i  (rom_q15_i),
        .data_o (packed_data)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        acc_load_d  = 1'b0;
        oe_load_d   = 1'b0;
        turn_load_d = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (rd_req_i) begin
                    ctl_d.st   = ST_WAIT;
                    ctl_d.addr = rd_addr_i[ADDR_W:1];
                    ctl_d.lsb  = rd_addr_i[0];
                    ctl_d.word = rd_word_i;
                    ctl_d.ce   = 1'b1;
                    acc_load_d = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!ctl_q.oe) begin
                    // address has settled for a cycle: open the output
                    ctl_d.oe  = 1'b1;
                    oe_load_d = 1'b1;
                end else if (acc_done && oe_done) begin
                    ctl_d.data  = packed_data;
                    ctl_d.valid = 1'b1;
                    ctl_d.oe    = 1'b0;
                    ctl_d.ce    = 1'b0;
                    ctl_d.st    = ST_TURN;
                    turn_load_d = 1'b1;
                end
            end
            ST_TURN: begin
                if (turn_done) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, lsb: 1'b0, word: 1'b0,
                       ce: 1'b0, oe: 1'b0, valid: 1'b0, data: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rom_pin_level #(.ACTIVE_HIGH(CE_ACTIVE_HIGH)) u_ce_pin (
        .on_i  (ctl_q.ce),
        .pin_o (rom_ce_o)
    );

    rom_pin_level #(.ACTIVE_HIGH(OE_ACTIVE_HIGH)) u_oe_pin (
        .on_i  (ctl_q.oe),
        .pin_o (rom_oe_o)
    );

    assign rom_addr_o   = ctl_q.addr;
    assign rom_word_o   = ctl_q.word;
    assign rom_q15_o    = ctl_q.lsb;
    assign rom_q15_oe_o = ctl_q.ce & ~ctl_q.word;
    assign rd_busy_o    = (ctl_q.st != ST_IDLE);
    assign rd_valid_o   = ctl_q.valid;
    assign rd_data_o    = ctl_q.data;
endmodule

// File: rtl/rom_rd_ctrl_chk.sv
module rom_rd_ctrl_chk #(
    parameter int unsigned ADDR_W         = 20,
    parameter int unsigned CLK_PERIOD_NS  = 10,
    parameter int unsigned T_DIS_NS       = 20,
    parameter bit          CE_ACTIVE_HIGH = 1'b0,
    parameter bit          OE_ACTIVE_HIGH = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_i,
    input logic              rd_busy_o,
    input logic              rd_valid_o,
    input logic [7:0]        data_hi,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              rom_word_o,
    input logic              rom_ce_o,
    input logic              rom_oe_o,
    input logic              rom_q15_o,
    input logic              rom_q15_oe_o
);
    localparam int unsigned TURN_MIN = (T_DIS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    logic ce_on, oe_on;
    assign ce_on = CE_ACTIVE_HIGH ? rom_ce_o : ~rom_ce_o;
    assign oe_on = OE_ACTIVE_HIGH ? rom_oe_o : ~rom_oe_o;

    // cycles since output-enable was last active, saturating
    logic [7:0] oe_off_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_off_cnt <= 8'hFF;
        end else if (oe_on) begin
            oe_off_cnt <= 8'h00;
        end else if (oe_off_cnt != 8'hFF) begin
            oe_off_cnt <= oe_off_cnt + 8'h01;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i && !rd_busy_o |=> rd_busy_o && ce_on);

    p_oe_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_on |-> ce_on);

    p_oe_after_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_on) |-> $past(ce_on));

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !ce_on && !oe_on);

    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rom_word_o |-> data_hi == 8'h00);

    p_shared_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_q15_oe_o |-> ce_on && !rom_word_o);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_q15_oe_o) |-> oe_off_cnt >= 8'(TURN_MIN));

    p_pins_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_on && $past(ce_on) |-> $stable(rom_addr_o) && $stable(rom_word_o) && $stable(rom_q15_o));
endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
    .ADDR_W         (ADDR_W),
    .CLK_PERIOD_NS  (CLK_PERIOD_NS),
    .T_DIS_NS       (T_DIS_NS),
    .CE_ACTIVE_HIGH (CE_ACTIVE_HIGH),
    .OE_ACTIVE_HIGH (OE_ACTIVE_HIGH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_i     (rd_req_i),
    .rd_busy_o    (rd_busy_o),
    .rd_valid_o   (rd_valid_o),
    .data_hi      (rd_data_o[15:8]),
    .rom_addr_o   (rom_addr_o),
    .rom_word_o   (rom_word_o),
    .rom_ce_o     (rom_ce_o),
    .rom_oe_o     (rom_oe_o),
    .rom_q15_o    (rom_q15_o),
    .rom_q15_oe_o (rom_q15_oe_o)
);

// File: tb/tb_rom_rd_ctrl.sv
module tb_rom_rd_ctrl;
    localparam int AW     = 20;
    localparam int CLK_NS = 10;
    localparam int ACC    = (100 + CLK_NS - 1) / CLK_NS;
    localparam int OEC    = (50 + CLK_NS - 1) / CLK_NS;
    localparam int TURN   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int CAP    = (ACC > OEC + 1) ? ACC : OEC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req = 1'b0;
    logic [AW:0]   haddr = '0;
    logic          hword = 1'b0;
    logic          busy, valid;
    logic [15:0]   rdata;
    logic [AW-1:0] maddr;
    logic          mword, mce, moe, q15o, q15oe;
    logic [14:0]   mdq = 15'h7FFF;
    logic          mq15 = 1'b1;
    logic          q15_pin;
    assign q15_pin = q15oe ? q15o : mq15;

    rom_rd_ctrl dut (
        .clk (clk), .rst_n (rst_n),
        .rd_req_i (req), .rd_addr_i (haddr), .rd_word_i (hword),
        .rd_busy_o (busy), .rd_valid_o (valid), .rd_data_o (rdata),
        .rom_addr_o (maddr), .rom_word_o (mword), .rom_ce_o (mce), .rom_oe_o (moe),
        .rom_dq_i (mdq), .rom_q15_i (q15_pin), .rom_q15_o (q15o), .rom_q15_oe_o (q15oe)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] pat(input logic [AW-1:0] w);
        logic [31:0] x;
        x = 32'(w) * 32'h0000_9E37;
        return x[15:0] ^ x[31:16] ^ w[15:0];
    endfunction

    function automatic logic [15:0] expect_data(input logic wmode, input logic [AW:0] a);
        logic [15:0] p;
        p = pat(a[AW:1]);
        if (wmode) return p;
        return a[0] ? {8'h00, p[15:8]} : {8'h00, p[7:0]};
    endfunction

    // reference: edge numbering and accept tracking
    int          ecnt = 0;
    int          n0 = -1000;
    logic [AW:0] acc_addr = '0;
    logic        acc_word = 1'b0;
    int          accepted = 0;
    int          pulses = 0;

    always @(posedge clk) begin
        if (rst_n && req && (ecnt - n0 >= CAP + TURN)) begin
            n0       = ecnt + 1;
            acc_addr = haddr;
            acc_word = hword;
            accepted++;
        end
        ecnt++;
    end

    // per-cycle comparison
    always @(negedge clk) begin
        int   d;
        logic e_ce, e_oe, e_busy, e_valid;
        if (rst_n && !done) begin
            d       = ecnt - n0;
            e_ce    = (d >= 0) && (d < CAP);
            e_oe    = (d >= 1) && (d < CAP);
            e_busy  = (d >= 0) && (d < CAP + TURN);
            e_valid = (d == CAP);
            check("R8 busy", 32'(busy), 32'(e_busy));
            check("R4 valid", 32'(valid), 32'(e_valid));
            check("R2/R11 ce pin", 32'(mce), 32'(!e_ce));
            check("R3/R11 oe pin", 32'(moe), 32'(!e_oe));
            check("R7 shared pin drive", 32'(q15oe), 32'(e_ce && !acc_word));
            if (e_ce) begin
                check("R2/R9/R10 address pins", 32'(maddr), 32'(acc_addr[AW:1]));
                check("R2 mode pin", 32'(mword), 32'(acc_word));
                if (!acc_word) check("R6 shared pin as address", 32'(q15o), 32'(acc_addr[0]));
            end
            if (e_valid) begin
                if (acc_word) check("R5 word data", 32'(rdata), 32'(expect_data(1'b1, acc_addr)));
                else          check("R6 byte data", 32'(rdata), 32'(expect_data(1'b0, acc_addr)));
            end
            if (valid) pulses++;
        end
    end

    // behavioural memory with cycle-granular access delays
    logic [AW-1:0] m_addr_l = '0;
    logic          m_lsb_l = 1'b0, m_word_l = 1'b0, m_ce_l = 1'b0, m_oe_l = 1'b0;
    int            m_addr_e = 0, m_ce_e = 0, m_oe_e = 0;

    always @(negedge clk) begin
        logic ce_on, oe_on, lsb, ok;
        logic [15:0] w;
        ce_on = !mce;
        oe_on = !moe;
        lsb   = mword ? 1'b0 : q15_pin;
        if (maddr != m_addr_l || lsb != m_lsb_l || mword != m_word_l) m_addr_e = ecnt;
        if (ce_on && !m_ce_l) m_ce_e = ecnt;
        if (oe_on && !m_oe_l) m_oe_e = ecnt;
        m_addr_l = maddr; m_lsb_l = lsb; m_word_l = mword; m_ce_l = ce_on; m_oe_l = oe_on;
        if (ce_on && oe_on) begin
            ok = (ecnt + 1 - m_addr_e >= ACC) && (ecnt + 1 - m_ce_e >= ACC) && (ecnt + 1 - m_oe_e >= OEC);
            w  = pat(maddr);
            if (!ok) begin
                mdq = 15'h2AAA; mq15 = 1'b1;
            end else if (mword) begin
                mdq = w[14:0]; mq15 = w[15];
            end else begin
                mdq = {7'h55, (lsb ? w[15:8] : w[7:0])}; mq15 = 1'b1;
            end
        end else begin
            mdq = 15'h7FFF; mq15 = 1'b1;
        end
    end

    task automatic do_read(input logic wmode, input logic [AW:0] a);
        while (busy) @(negedge clk);
        req = 1'b1; hword = wmode; haddr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [AW:0] lf;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 valid in reset", 32'(valid), 32'd0);
        check("R1 data in reset", 32'(rdata), 32'd0);
        check("R1/R11 ce pin idle high", 32'(mce), 32'd1);
        check("R1/R11 oe pin idle high", 32'(moe), 32'd1);
        check("R1 shared pin undriven", 32'(q15oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_read(1'b1, 21'h000000);
        do_read(1'b1, 21'h1FFFFE);
        do_read(1'b1, 21'h02469B);   // odd byte address, bit 0 unused in word mode
        do_read(1'b0, 21'h000001);
        do_read(1'b0, 21'h000000);
        do_read(1'b0, 21'h1FFFFF);
        do_read(1'b1, 21'h1FFFFF);
        do_read(1'b0, 21'h0ABCDE);
        do_read(1'b1, 21'h0ABCDE);

        lf = 21'h1ACE5;
        for (int i = 0; i < 24; i++) begin
            lf = {lf[AW-1:0], lf[AW] ^ lf[AW-2]};
            do_read(lf[3], lf);
        end

        // R9: strobe held through busy while host inputs change
        while (busy) @(negedge clk);
        req = 1'b1; hword = 1'b1; haddr = 21'h155554;
        repeat (4) @(negedge clk);
        hword = 1'b0; haddr = 21'h0AAAAB;
        repeat (3 * (CAP + TURN)) @(negedge clk);
        req = 1'b0;

        repeat (CAP + TURN + 4) @(negedge clk);
        check("R9 one valid per accepted strobe", 32'(pulses), 32'(accepted));
        check("R9 held strobe accepted only when idle", 32'(accepted > 33), 32'd1);
        finish_run();
    end
endmodule